// File: doc/BRIEF.md
# Static Dataflow Template Engine

This block keeps a small store of dataflow instruction templates for a single processing element. Each template holds an operation code, two destination references and two operand slots (left and right), and each slot has its own presence flag. Tokens arriving on the input port name a template, a side and a value. The block writes the value into that slot. A template whose two slots are both filled, and whose used destination slots are all empty, is ready to fire.

One ready template is chosen per cycle by a rotating arbiter. Its operands go through a small integer ALU, both of its slots are emptied, and the result leaves on the output port as one token per used destination, each token naming the destination template and side. The surrounding network (here the testbench) routes those tokens back to the input. Every arc stores at most one token. A token aimed at an occupied slot waits at the input until that slot is consumed. Templates are written through a preload port.

Top module: `dfe_engine`

## Requirements
- R1: After reset no output token is offered (`out_valid` = 0), every operand slot is empty so `in_ready` is 1 for any slot address, and every template is a pass-through whose two destinations are unused.
- R2: An input token is accepted (`in_valid` and `in_ready` both 1 at a rising edge) only when the slot it addresses is empty, with `in_port` 0 = left and 1 = right. While that slot is full, or while `pl_valid` is 1, `in_ready` is 0 and the token waits.
- R3: A template fires only when both of its operand slots are full, each used destination slot is empty, the output stage holds no token, and no preload is active. Both of its operand slots are empty from the firing edge onwards.
- R4: The result is computed from the operation code as follows: 0 gives left+right, 1 gives left-right, 2 gives left*right (all modulo 2^DATA_W), and 3 passes the left operand through unchanged.
- R5: A destination field is {use, index, side}, with the use bit as the MSB and the side bit as the LSB. The token for destination 0 is offered first and the token for destination 1 follows, each carrying the destination index and side and the same result.
- R6: A destination whose use bit is 0 produces no token. A template whose two destinations are both unused fires and discards its result.
- R7: When several templates are ready, the grant rotates. The template searched first is the one after the last granted index, and the search starts at index 0 after reset.
- R8: While `out_valid` is 1 and `out_ready` is 0, the offered index, side and data stay unchanged and `out_valid` stays 1.
- R9: A preload (`pl_valid` = 1) writes the operation code and both destination fields of template `pl_idx` and empties both of its operand slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_valid | input | 1 | Preload strobe for one template |
| pl_idx | input | IDX_W | Template being preloaded |
| pl_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 pass) |
| pl_dst0 | input | IDX_W+2 | First destination {use, index, side} |
| pl_dst1 | input | IDX_W+2 | Second destination {use, index, side} |
| in_valid | input | 1 | Input token offered |
| in_ready | output | 1 | Addressed slot is free and the token may enter |
| in_idx | input | IDX_W | Target template of the input token |
| in_port | input | 1 | Target side: 0 left, 1 right |
| in_data | input | DATA_W | Token value |
| out_valid | output | 1 | Result token offered |
| out_ready | input | 1 | Network accepts the result token |
| out_idx | output | IDX_W | Destination template of the result token |
| out_port | output | 1 | Destination side of the result token |
| out_data | output | DATA_W | Result value |

## Verification
The main function is exercised with a five-template expression graph on random operand pairs. The bench loops every result token back to the input while it applies random output back-pressure. Each token is compared with the value expected for the slot it addresses, which separates add, subtract and multiply results, destination ordering, and stability of the held token. Directed patterns cover the rest. A second token aimed at an already full slot shows the input hold. A destination slot filled in advance shows that firing waits for the slot to empty. Templates with no used destination show that the result is discarded. Three templates that become ready while the output is busy show whether the grant order rotates or is fixed. A preload onto a partly filled template shows the slot clear.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_PASS = 2'd3
  } dfe_op_e;

endpackage

// File: rtl/dfe_rr_arb.sv
module dfe_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);

  logic [IW-1:0] last_q;

  // Search begins one past the last winner and wraps around.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      automatic int c = (int'(last_q) + 1 + k) % N;
      if (en && !any && req[c]) begin
        any     = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= IW'(N - 1);
    else if (any) last_q <= gnt_idx;
  end

endmodule

// File: rtl/dfe_out_stage.sv
module dfe_out_stage #(
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] res,
  input  logic          d0_use,
  input  logic [IW-1:0] d0_idx,
  input  logic          d0_port,
  input  logic          d1_use,
  input  logic [IW-1:0] d1_idx,
  input  logic          d1_port,
  output logic          idle,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic          out_port,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);

  logic          pend_q;
  logic [IW-1:0] pend_idx_q;
  logic          pend_port_q;

  assign idle = !out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_idx     <= '0;
      out_port    <= 1'b0;
      out_data    <= '0;
      pend_q      <= 1'b0;
      pend_idx_q  <= '0;
      pend_port_q <= 1'b0;
    end else if (load) begin
      out_data    <= res;
      pend_idx_q  <= d1_idx;
      pend_port_q <= d1_port;
      if (d0_use) begin
        out_valid <= 1'b1;
        out_idx   <= d0_idx;
        out_port  <= d0_port;
        pend_q    <= d1_use;
      end else if (d1_use) begin
        out_valid <= 1'b1;
        out_idx   <= d1_idx;
        out_port  <= d1_port;
        pend_q    <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        pend_q    <= 1'b0;
      end
    end else if (out_valid && out_ready) begin
      if (pend_q) begin
        out_idx  <= pend_idx_q;
        out_port <= pend_port_q;
        pend_q   <= 1'b0;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dfe_engine.sv
module dfe_engine
  import dfe_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int DST_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_valid,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [1:0]        pl_op,
  input  logic [DST_W-1:0]  pl_dst0,
  input  logic [DST_W-1:0]  pl_dst1,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic              in_port,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_port,
  output logic [DATA_W-1:0] out_data
);

  dfe_op_e           op_q   [N_NODES];
  logic [DST_W-1:0]  dst0_q [N_NODES];
  logic [DST_W-1:0]  dst1_q [N_NODES];
  logic [DATA_W-1:0] opl_q  [N_NODES];
  logic [DATA_W-1:0] opr_q  [N_NODES];
  logic [N_NODES-1:0] pres_l, pres_r, ready_vec, gnt;

  // Named internal events used by the checker.
  logic              in_take;
  logic              fire;
  logic [IDX_W-1:0]  fire_idx;
  logic [DATA_W-1:0] fire_res;
  logic              out_idle;

  function automatic logic [DATA_W-1:0] alu_eval(dfe_op_e op,
                                                 logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return a * b;
      default: return a;
    endcase
  endfunction

  // A destination blocks firing when it is used and its slot still holds a token.
  function automatic logic dst_blocked(logic [DST_W-1:0] d,
                                       logic [N_NODES-1:0] pl,
                                       logic [N_NODES-1:0] pr);
    logic [IDX_W-1:0] k;
    k = d[DST_W-2:1];
    return d[DST_W-1] && (d[0] ? pr[k] : pl[k]);
  endfunction

  assign in_ready = !pl_valid && (in_port ? !pres_r[in_idx] : !pres_l[in_idx]);
  assign in_take  = in_valid && in_ready;

  for (genvar gi = 0; gi < N_NODES; gi++) begin : g_ready
    assign ready_vec[gi] = pres_l[gi] && pres_r[gi]
                        && !dst_blocked(dst0_q[gi], pres_l, pres_r)
                        && !dst_blocked(dst1_q[gi], pres_l, pres_r);
  end

  dfe_rr_arb #(.N(N_NODES)) arb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (ready_vec),
    .en      (out_idle && !pl_valid),
    .gnt     (gnt),
    .gnt_idx (fire_idx),
    .any     (fire)
  );

  assign fire_res = alu_eval(op_q[fire_idx], opl_q[fire_idx], opr_q[fire_idx]);

  dfe_out_stage #(.DW(DATA_W), .IW(IDX_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .res       (fire_res),
    .d0_use    (dst0_q[fire_idx][DST_W-1]),
    .d0_idx    (dst0_q[fire_idx][DST_W-2:1]),
    .d0_port   (dst0_q[fire_idx][0]),
    .d1_use    (dst1_q[fire_idx][DST_W-1]),
    .d1_idx    (dst1_q[fire_idx][DST_W-2:1]),
    .d1_port   (dst1_q[fire_idx][0]),
    .idle      (out_idle),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_port  (out_port),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_l <= '0;
      pres_r <= '0;
      for (int i = 0; i < N_NODES; i++) begin
        op_q[i]   <= OP_PASS;
        dst0_q[i] <= '0;
        dst1_q[i] <= '0;
        opl_q[i]  <= '0;
        opr_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N_NODES; i++) begin
        if (pl_valid && pl_idx == IDX_W'(i)) begin
          op_q[i]   <= dfe_op_e'(pl_op);
          dst0_q[i] <= pl_dst0;
          dst1_q[i] <= pl_dst1;
          pres_l[i] <= 1'b0;
          pres_r[i] <= 1'b0;
        end else begin
          if (fire && fire_idx == IDX_W'(i)) begin
            pres_l[i] <= 1'b0;
            pres_r[i] <= 1'b0;
          end
          if (in_take && in_idx == IDX_W'(i)) begin
            if (in_port) begin
              pres_r[i] <= 1'b1;
              opr_q[i]  <= in_data;
            end else begin
              pres_l[i] <= 1'b1;
              opl_q[i]  <= in_data;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/dfe_engine_chk.sv
module dfe_engine_chk #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fire,
  input logic [IW-1:0] fire_idx,
  input logic [N-1:0]  gnt,
  input logic [N-1:0]  pres_l,
  input logic [N-1:0]  pres_r,
  input logic          pl_valid,
  input logic [IW-1:0] pl_idx,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_idx,
  input logic          out_port,
  input logic [DW-1:0] out_data
);

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_fire_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (pres_l[fire_idx] && pres_r[fire_idx]));

  assert_fire_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!pres_l[$past(fire_idx)] && !pres_r[$past(fire_idx)]));

  assert_fire_out_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !out_valid);

  assert_no_fire_in_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> !fire);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_idx) && $stable(out_port)));

  assert_preload_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |=> (!pres_l[$past(pl_idx)] && !pres_r[$past(pl_idx)]));

endmodule

bind dfe_engine dfe_engine_chk #(.N(N_NODES), .IW(IDX_W), .DW(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .fire_idx  (fire_idx),
  .gnt       (gnt),
  .pres_l    (pres_l),
  .pres_r    (pres_r),
  .pl_valid  (pl_valid),
  .pl_idx    (pl_idx),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_idx   (out_idx),
  .out_port  (out_port),
  .out_data  (out_data)
);

// File: tb/dfe_engine_tb_top.sv
module dfe_engine_tb_top;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int TW = IW + 1 + DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pl_valid = 1'b0;
  logic [IW-1:0] pl_idx = '0;
  logic [1:0]    pl_op = '0;
  logic [IW+1:0] pl_dst0 = '0, pl_dst1 = '0;
  logic          in_valid = 1'b0, in_ready;
  logic [IW-1:0] in_idx = '0;
  logic          in_port = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [IW-1:0] out_idx;
  logic          out_port;
  logic [DW-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  dfe_engine #(.N_NODES(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pl_valid(pl_valid), .pl_idx(pl_idx), .pl_op(pl_op),
    .pl_dst0(pl_dst0), .pl_dst1(pl_dst1),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .in_port(in_port), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_port(out_port), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [IW+1:0] dst(input bit use_it, input int idx, input bit side);
    return {use_it, IW'(idx), side};
  endfunction

  // Expected value for each slot of the expression graph.
  function automatic logic [DW-1:0] graph_exp(input int idx, input bit side,
                                              input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] s, m, d, p;
    s = a + b;
    m = b * 16'd7;
    d = s - m;
    p = s + m;
    case ({idx[2:0], side})
      {3'd2, 1'b0}, {3'd3, 1'b0}: return s;
      {3'd2, 1'b1}, {3'd3, 1'b1}: return m;
      {3'd4, 1'b0}: return d;
      {3'd4, 1'b1}: return p;
      {3'd5, 1'b0}: return d * p;
      default: return 16'hDEAD;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; pl_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic preload(input int idx, input int op, input logic [IW+1:0] d0, input logic [IW+1:0] d1);
    @(negedge clk);
    pl_valid = 1'b1; pl_idx = IW'(idx); pl_op = 2'(op); pl_dst0 = d0; pl_dst1 = d1;
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  task automatic push(input int idx, input bit side, input logic [DW-1:0] v);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1; in_idx = IW'(idx); in_port = side; in_data = v;
    do begin
      #9 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic probe_ready(input int idx, input bit side, input bit exp, input string req);
    @(negedge clk);
    in_valid = 1'b0; in_idx = IW'(idx); in_port = side;
    #1 check(in_ready === exp, req, in_ready, exp);
  endtask

  task automatic run_graph(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [TW-1:0] q[$];
    logic [TW-1:0] last_tok, stall_tok;
    bit done = 0, stalled = 0;
    int ntok = 0;
    q.push_back({3'd0, 1'b0, a}); q.push_back({3'd0, 1'b1, b});
    q.push_back({3'd1, 1'b0, b}); q.push_back({3'd1, 1'b1, 16'd7});
    last_tok = '0;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (q.size() > 0) begin
        in_valid = 1'b1;
        {in_idx, in_port, in_data} = q[0];
      end else in_valid = 1'b0;
      #9;
      if (stalled) begin
        check(out_valid && {out_idx, out_port, out_data} == stall_tok,
              "R8 held token", {out_idx, out_port, out_data}, stall_tok);
      end
      stalled = out_valid && !out_ready;
      stall_tok = {out_idx, out_port, out_data};
      if (in_valid && in_ready) void'(q.pop_front());
      if (out_valid && out_ready) begin
        ntok++;
        check(out_data == graph_exp(out_idx, out_port, a, b), "R4 result value",
              out_data, graph_exp(out_idx, out_port, a, b));
        if ({out_idx, out_port} == {3'd3, 1'b0} || {out_idx, out_port} == {3'd3, 1'b1})
          check(last_tok[TW-1:DW] == {3'd2, out_port}, "R5 dest0 before dest1",
                last_tok[TW-1:DW], {3'd2, out_port});
        last_tok = {out_idx, out_port, out_data};
        if (out_idx == 3'd5) done = 1;
        else q.push_back({out_idx, out_port, out_data});
      end
    end
    check(done && ntok == 7, "R5 token count", ntok, 7);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    #1 check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    probe_ready(0, 0, 1, "R1 slot empty");
    probe_ready(7, 1, 1, "R1 slot empty");

    // R2 hold on full slot; R6 sink when no destinations; R3 clear after firing
    push(6, 0, 16'd11);
    probe_ready(6, 0, 0, "R2 full slot holds");
    push(6, 1, 16'd5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1 check(out_valid === 1'b0, "R6 no token when unused", out_valid, 0);
    end
    probe_ready(6, 0, 1, "R3 slot cleared after firing");
    // R2 preload blocks input
    @(negedge clk); pl_valid = 1'b1; pl_idx = 3'd1; pl_op = 2'd3; pl_dst0 = '0; pl_dst1 = '0;
    in_idx = 3'd0; in_port = 1'b0;
    #1 check(in_ready === 1'b0, "R2 preload blocks input", in_ready, 0);
    @(negedge clk); pl_valid = 1'b0;

    // R9 preload empties slots
    push(7, 0, 16'd3);
    probe_ready(7, 0, 0, "R9 slot full before preload");
    preload(7, 3, '0, '0);
    probe_ready(7, 0, 1, "R9 preload empties slot");

    // R3 destination gating; R5 single dest token; R4 pass-through
    do_reset();
    preload(6, 3, dst(1, 7, 0), dst(0, 0, 0));
    push(7, 0, 16'd100);
    push(6, 0, 16'd42);
    push(6, 1, 16'd9);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1 check(out_valid === 1'b0, "R3 waits for full destination", out_valid, 0);
    end
    probe_ready(6, 0, 0, "R3 operands kept while blocked");
    push(7, 1, 16'd1);
    begin
      bit seen = 0;
      for (int k = 0; k < 10 && !seen; k++) begin
        @(negedge clk); #9;
        if (out_valid) begin
          seen = 1;
          check({out_idx, out_port} == {3'd7, 1'b0}, "R5 destination address",
                {out_idx, out_port}, {3'd7, 1'b0});
          check(out_data == 16'd42, "R4 pass-through", out_data, 42);
        end
      end
      check(seen, "R3 fires after destination empties", seen, 1);
      @(negedge clk); #1 check(out_valid === 1'b0, "R6 single destination", out_valid, 0);
    end

    // R7 rotating grant
    do_reset();
    for (int i = 0; i < 3; i++) preload(i, 3, dst(1, 4 + i, 0), dst(0, 0, 0));
    out_ready = 1'b0;
    push(0, 0, 16'd10); push(0, 1, 16'd0);
    push(1, 0, 16'd20); push(1, 1, 16'd0);
    push(2, 0, 16'd30); push(2, 1, 16'd0);
    push(0, 0, 16'd11); push(0, 1, 16'd0);
    begin
      int exp_idx[4] = '{4, 5, 6, 4};
      int exp_dat[4] = '{10, 20, 30, 11};
      int got = 0;
      for (int k = 0; k < 40 && got < 4; k++) begin
        @(negedge clk); out_ready = 1'b1; #9;
        if (out_valid) begin
          check(out_idx == IW'(exp_idx[got]) && out_data == DW'(exp_dat[got]),
                "R7 grant order", out_data, exp_dat[got]);
          got++;
        end
      end
      check(got == 4, "R7 all granted", got, 4);
    end

    // R4 R5 R8 random expression graph
    do_reset();
    preload(0, 0, dst(1, 2, 0), dst(1, 3, 0));
    preload(1, 2, dst(1, 2, 1), dst(1, 3, 1));
    preload(2, 1, dst(1, 4, 0), dst(0, 0, 0));
    preload(3, 0, dst(1, 4, 1), dst(0, 0, 0));
    preload(4, 2, dst(1, 5, 0), dst(0, 0, 0));
    run_graph(16'd0, 16'd0);
    run_graph(16'hFFFF, 16'h2493);
    for (int it = 0; it < 25; it++) run_graph(DW'($urandom), DW'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule